// File: doc/BRIEF.md
# CAN Receive Mailbox Bank

This block holds the receive side of a CAN controller's mailbox array. A bit-level receive engine hands it one completed frame at a time (identifier, format flag, remote flag, length code and eight data bytes) as a single-cycle strobe. In that same clock edge the bank filters the frame against every mailbox, picks one destination, and writes the frame there. The stored frame carries a timestamp taken from a free-running local time counter.

Each mailbox has an identifier word, an acceptance mask word, a control word, two data words and a timestamp. Per-mailbox enable, direction, pending, lost and protect bits sit in bank-wide vector registers. Protected mailboxes that already hold an unread frame are passed over, so a run of protected mailboxes fills one after another like a receive FIFO. An unprotected mailbox at the end of that run takes the overflow: its old frame is overwritten and its lost bit is raised. When every matching mailbox is protected and full, the frame is discarded and a sticky bank-level overflow flag is set.

Top module: `can_rx_mbox_bank`

## Requirements
- R1: After reset the vector registers (enable, direction, pending, lost, protect), the status word, all mailbox words, the time counter and `rd_data` read as zero.
- R2: A mailbox takes part in reception only when its enable bit and its direction bit (1 = receive) are both set.
- R3: Identifier word: bit 31 = extended format, bit 30 = mask enable, bit 29 = auto-answer (stored only). A standard identifier is compared at bits [28:18], an extended one at [28:0]. With bit 30 set, a mask bit of 1 makes that identifier bit a don't-care, and mask bit 31 makes the format a don't-care; otherwise the format bits must agree.
- R4: Mailboxes are searched from the highest index downward, and the first one that may accept the frame receives it.
- R5: On a store, identifier word bits 31 and [28:0] take the frame's format and identifier (bits 30:29 kept); the control word is {27'b0, rtr, dlc}; data-low is {byte0, byte1, byte2, byte3} and data-high {byte4..byte7}, byte 0 most significant. Input byte i sits at `rx_data[8i+7:8i]`.
- R6: The time counter starts at 0 after reset and advances by one each clock; a stored frame's timestamp equals the counter value at the storing edge.
- R7: A store sets the mailbox's pending bit; writing 1 to a pending bit clears it, and a store in the same cycle wins over the clear.
- R8: A mailbox with protect and pending both set is skipped and the search continues downward.
- R9: A mailbox with protect clear and pending set is overwritten and its lost bit is set; lost bits clear by writing 1, a new set winning.
- R10: A frame that matches at least one eligible mailbox but finds none that may accept it is discarded and sets status bit 0, which stays set until 1 is written to it.
- R11: `rd_data` is registered: it shows, one clock after `rd_addr` is presented, the register value as it stood before that clock edge.
- R12: A frame that matches no eligible mailbox changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: a completed frame is present |
| rx_ext | input | 1 | Frame uses the 29-bit identifier format |
| rx_rtr | input | 1 | Remote frame |
| rx_dlc | input | 4 | Data length code |
| rx_id | input | 29 | Identifier; standard frames use bits [10:0] |
| rx_data | input | 64 | Data bytes, byte i at [8i+7:8i] |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write address {kind[2:0], index[4:0]} |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read address {kind[2:0], index[4:0]} |
| rd_data | output | 32 | Registered read data |

Address kinds: 0 identifier, 1 control, 2 data-low, 3 data-high, 4 timestamp, 5 mask (index = mailbox); 6 bank registers with index 0 enable, 1 direction, 2 pending, 3 lost, 4 protect, 5 status, 6 time; kind 7 reads zero.

## Verification
Every frame and every register write takes effect at the single clock edge where it is presented, and every read returns one edge later, so a result is due exactly one cycle after its stimulus. The bench drives inputs on the falling edge, updates its reference model once per rising edge using the state before that edge, and compares `rd_data` against the model on every falling edge. Directed reads with fixed expected values are placed right after the frame or write under test, so each one observes the state that stimulus left.

// File: rtl/can_mbx_pkg.sv
package can_mbx_pkg;

  localparam int WORD_W = 32;
  localparam int ID_W   = 29;

  typedef enum logic [2:0] {
    K_ID    = 3'd0,
    K_CTRL  = 3'd1,
    K_DLO   = 3'd2,
    K_DHI   = 3'd3,
    K_STAMP = 3'd4,
    K_MASK  = 3'd5,
    K_GLOB  = 3'd6,
    K_NONE  = 3'd7
  } reg_kind_e;

  typedef enum logic [2:0] {
    G_EN   = 3'd0,
    G_DIR  = 3'd1,
    G_PEND = 3'd2,
    G_LOST = 3'd3,
    G_PROT = 3'd4,
    G_STAT = 3'd5,
    G_TIME = 3'd6,
    G_RSVD = 3'd7
  } glob_sel_e;

  typedef struct packed {
    logic            ext;
    logic            rtr;
    logic [3:0]      dlc;
    logic [ID_W-1:0] id;
    logic [63:0]     data;
  } rx_frame_t;

  // identifier as placed in the identifier word
  function automatic logic [ID_W-1:0] id_field(input logic ext, input logic [ID_W-1:0] id);
    id_field = ext ? id : {id[10:0], 18'd0};
  endfunction

  // acceptance test of one mailbox against an incoming frame
  function automatic logic id_accept(input logic [WORD_W-1:0] mid,
                                     input logic [WORD_W-1:0] mask,
                                     input logic ext,
                                     input logic [ID_W-1:0] fid);
    logic            ame;
    logic [ID_W-1:0] care;
    logic            fmt_ok;
    ame  = mid[30];
    care = ame ? ~mask[ID_W-1:0] : {ID_W{1'b1}};
    if (!ext) care[17:0] = '0;
    fmt_ok    = (ame && mask[31]) || (mid[31] == ext);
    id_accept = fmt_ok && (((fid ^ mid[ID_W-1:0]) & care) == '0);
  endfunction

  function automatic logic [WORD_W-1:0] data_lo(input logic [63:0] d);
    data_lo = {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  function automatic logic [WORD_W-1:0] data_hi(input logic [63:0] d);
    data_hi = {d[39:32], d[47:40], d[55:48], d[63:56]};
  endfunction

  function automatic logic [WORD_W-1:0] ctrl_word(input logic rtr, input logic [3:0] dlc);
    ctrl_word = {27'd0, rtr, dlc};
  endfunction

endpackage

// File: rtl/mbx_time_base.sv
module mbx_time_base #(
  parameter int TIME_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [TIME_W-1:0] now_o
);

  logic [TIME_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;
  end

  assign now_o = cnt_q;

endmodule

// File: rtl/mbx_accept_filter.sv
module mbx_accept_filter
  import can_mbx_pkg::*;
#(
  parameter int NUM = 32
) (
  input  logic [NUM-1:0][WORD_W-1:0] mid_i,
  input  logic [NUM-1:0][WORD_W-1:0] mask_i,
  input  logic [NUM-1:0]             en_i,
  input  logic [NUM-1:0]             dir_i,
  input  logic [NUM-1:0]             pend_i,
  input  logic [NUM-1:0]             prot_i,
  input  rx_frame_t                  frame_i,
  output logic [NUM-1:0]             match_o,
  output logic [NUM-1:0]             cand_o
);

  logic [ID_W-1:0] fid;
  assign fid = id_field(frame_i.ext, frame_i.id);

  for (genvar m = 0; m < NUM; m++) begin : g_flt
    assign match_o[m] = en_i[m] & dir_i[m] & id_accept(mid_i[m], mask_i[m], frame_i.ext, fid);
    assign cand_o[m]  = match_o[m] & ~(pend_i[m] & prot_i[m]);
  end

endmodule

// File: rtl/mbx_pick.sv
module mbx_pick #(
  parameter int NUM   = 32,
  localparam int IDX_W = $clog2(NUM)
) (
  input  logic [NUM-1:0]   cand_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);

  // ascending scan; the last hit is the highest index
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = 0; i < NUM; i++) begin
      if (cand_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/can_rx_mbox_bank.sv
module can_rx_mbox_bank
  import can_mbx_pkg::*;
#(
  parameter int NUM    = 32,
  parameter int TIME_W = 32,
  localparam int IDX_W  = $clog2(NUM),
  localparam int SUB_W  = (IDX_W > 3) ? IDX_W : 3,
  localparam int ADDR_W = SUB_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic              rx_ext,
  input  logic              rx_rtr,
  input  logic [3:0]        rx_dlc,
  input  logic [ID_W-1:0]   rx_id,
  input  logic [63:0]       rx_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);

  localparam logic [SUB_W:0] NUM_L = (SUB_W + 1)'(NUM);

  // ---------------- state ----------------
  logic [NUM-1:0][WORD_W-1:0] mid_q, mask_q, ctl_q, dlo_q, dhi_q;
  logic [NUM-1:0][TIME_W-1:0] ts_q;
  logic [NUM-1:0]             en_q, dir_q, pend_q, lost_q, prot_q;
  logic                       glost_q;
  logic [WORD_W-1:0]          rd_data_q;

  // ---------------- named events ----------------
  rx_frame_t         frame;
  logic [TIME_W-1:0] now;
  logic [NUM-1:0]    match_vec, cand_vec, store_vec;
  logic              found, store_fire, drop_fire;
  logic [IDX_W-1:0]  store_idx;

  assign frame = '{ext: rx_ext, rtr: rx_rtr, dlc: rx_dlc, id: rx_id, data: rx_data};

  mbx_time_base #(.TIME_W(TIME_W)) i_time (
    .clk   (clk),
    .rst_n (rst_n),
    .now_o (now)
  );

  mbx_accept_filter #(.NUM(NUM)) i_filter (
    .mid_i   (mid_q),
    .mask_i  (mask_q),
    .en_i    (en_q),
    .dir_i   (dir_q),
    .pend_i  (pend_q),
    .prot_i  (prot_q),
    .frame_i (frame),
    .match_o (match_vec),
    .cand_o  (cand_vec)
  );

  mbx_pick #(.NUM(NUM)) i_pick (
    .cand_i  (cand_vec),
    .found_o (found),
    .idx_o   (store_idx)
  );

  assign store_fire = rx_valid && found;
  assign drop_fire  = rx_valid && (match_vec != '0) && !found;
  assign store_vec  = store_fire ? (NUM'(1) << store_idx) : '0;

  // ---------------- write decode ----------------
  reg_kind_e      wr_kind;
  logic [SUB_W-1:0] wr_sub;
  logic           wr_glob;
  glob_sel_e      wr_gsel;
  logic [NUM-1:0] pend_clr, lost_clr;

  assign wr_kind  = reg_kind_e'(wr_addr[ADDR_W-1 -: 3]);
  assign wr_sub   = wr_addr[SUB_W-1:0];
  assign wr_glob  = wr_en && (wr_kind == K_GLOB) && ((wr_sub >> 3) == '0);
  assign wr_gsel  = glob_sel_e'(wr_sub[2:0]);
  assign pend_clr = (wr_glob && wr_gsel == G_PEND) ? wr_data[NUM-1:0] : '0;
  assign lost_clr = (wr_glob && wr_gsel == G_LOST) ? wr_data[NUM-1:0] : '0;

  // ---------------- mailbox words ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mid_q  <= '0;
      mask_q <= '0;
      ctl_q  <= '0;
      dlo_q  <= '0;
      dhi_q  <= '0;
      ts_q   <= '0;
    end else begin
      for (int m = 0; m < NUM; m++) begin
        if (store_vec[m]) begin
          mid_q[m] <= {frame.ext, mid_q[m][30:29], id_field(frame.ext, frame.id)};
          ctl_q[m] <= ctrl_word(frame.rtr, frame.dlc);
          dlo_q[m] <= data_lo(frame.data);
          dhi_q[m] <= data_hi(frame.data);
          ts_q[m]  <= now;
        end else if (wr_en && wr_kind == K_ID && wr_sub == SUB_W'(m)) begin
          mid_q[m] <= wr_data;
        end
        if (wr_en && wr_kind == K_MASK && wr_sub == SUB_W'(m)) mask_q[m] <= wr_data;
      end
    end
  end

  // ---------------- bank vectors ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      dir_q   <= '0;
      prot_q  <= '0;
      pend_q  <= '0;
      lost_q  <= '0;
      glost_q <= 1'b0;
    end else begin
      if (wr_glob && wr_gsel == G_EN)   en_q   <= wr_data[NUM-1:0];
      if (wr_glob && wr_gsel == G_DIR)  dir_q  <= wr_data[NUM-1:0];
      if (wr_glob && wr_gsel == G_PROT) prot_q <= wr_data[NUM-1:0];
      pend_q <= (pend_q & ~pend_clr) | store_vec;
      lost_q <= (lost_q & ~lost_clr) | (store_vec & pend_q);
      if (drop_fire)                                   glost_q <= 1'b1;
      else if (wr_glob && wr_gsel == G_STAT && wr_data[0]) glost_q <= 1'b0;
    end
  end

  // ---------------- read path ----------------
  reg_kind_e        rd_kind;
  logic [SUB_W-1:0] rd_sub;
  logic [IDX_W-1:0] rd_idx;
  logic             rd_in_range;
  logic [WORD_W-1:0] rd_d;

  assign rd_kind     = reg_kind_e'(rd_addr[ADDR_W-1 -: 3]);
  assign rd_sub      = rd_addr[SUB_W-1:0];
  assign rd_idx      = rd_sub[IDX_W-1:0];
  assign rd_in_range = ({1'b0, rd_sub} < NUM_L);

  always_comb begin
    rd_d = '0;
    case (rd_kind)
      K_ID:    if (rd_in_range) rd_d = mid_q[rd_idx];
      K_CTRL:  if (rd_in_range) rd_d = ctl_q[rd_idx];
      K_DLO:   if (rd_in_range) rd_d = dlo_q[rd_idx];
      K_DHI:   if (rd_in_range) rd_d = dhi_q[rd_idx];
      K_STAMP: if (rd_in_range) rd_d = WORD_W'(ts_q[rd_idx]);
      K_MASK:  if (rd_in_range) rd_d = mask_q[rd_idx];
      K_GLOB: begin
        if ((rd_sub >> 3) == '0) begin
          case (glob_sel_e'(rd_sub[2:0]))
            G_EN:    rd_d = WORD_W'(en_q);
            G_DIR:   rd_d = WORD_W'(dir_q);
            G_PEND:  rd_d = WORD_W'(pend_q);
            G_LOST:  rd_d = WORD_W'(lost_q);
            G_PROT:  rd_d = WORD_W'(prot_q);
            G_STAT:  rd_d = WORD_W'(glost_q);
            G_TIME:  rd_d = WORD_W'(now);
            default: rd_d = '0;
          endcase
        end
      end
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data_q <= '0;
    else        rd_data_q <= rd_d;
  end

  assign rd_data = rd_data_q;

  // ---------------- assertions ----------------
  AST_ONLY_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    store_fire |-> (en_q[store_idx] && dir_q[store_idx])); // R2
  AST_HIGHEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    store_fire |-> ((cand_vec >> store_idx) == NUM'(1))); // R4
  AST_STAMP_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    store_fire |=> (ts_q[$past(store_idx)] == $past(now))); // R6
  AST_PEND_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    store_fire |=> pend_q[$past(store_idx)]); // R7
  AST_PROT_SKIPPED: assert property (@(posedge clk) disable iff (!rst_n)
    store_fire |-> !(pend_q[store_idx] && prot_q[store_idx])); // R8
  AST_LOST_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    (store_fire && pend_q[store_idx]) |=> lost_q[$past(store_idx)]); // R9
  AST_DROP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    drop_fire |=> glost_q); // R10

endmodule

// File: tb/test_can_rx_mbox_bank.sv
module test_can_rx_mbox_bank;

  localparam int NUM = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0, rx_ext = 1'b0, rx_rtr = 1'b0;
  logic [3:0]  rx_dlc = '0;
  logic [28:0] rx_id = '0;
  logic [63:0] rx_data = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;

  always #10 clk = ~clk;

  can_rx_mbox_bank i_can_rx_mbox_bank (
    .clk(clk), .rst_n(rst_n),
    .rx_valid(rx_valid), .rx_ext(rx_ext), .rx_rtr(rx_rtr), .rx_dlc(rx_dlc),
    .rx_id(rx_id), .rx_data(rx_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  int    n_tests = 0, n_fail = 0;
  bit    done = 0;
  string tag = "R1";

  // ---------------- reference model ----------------
  logic [31:0] m_mid [NUM], m_mask [NUM], m_ctl [NUM], m_dlo [NUM], m_dhi [NUM], m_ts [NUM];
  logic [31:0] m_en = 0, m_dir = 0, m_pend = 0, m_lost = 0, m_prot = 0, m_time = 0;
  bit          m_glost = 0;

  initial for (int k = 0; k < NUM; k++) begin
    m_mid[k] = 0; m_mask[k] = 0; m_ctl[k] = 0; m_dlo[k] = 0; m_dhi[k] = 0; m_ts[k] = 0;
  end

  function automatic logic [7:0] A(input int kind, input int sub);
    return {kind[2:0], sub[4:0]};
  endfunction

  function automatic logic [31:0] model_read(input logic [7:0] a);
    int kind = a[7:5];
    int sub  = a[4:0];
    case (kind)
      0: return m_mid[sub];
      1: return m_ctl[sub];
      2: return m_dlo[sub];
      3: return m_dhi[sub];
      4: return m_ts[sub];
      5: return m_mask[sub];
      6: case (sub)
           0: return m_en;
           1: return m_dir;
           2: return m_pend;
           3: return m_lost;
           4: return m_prot;
           5: return {31'd0, m_glost};
           6: return m_time;
           default: return 0;
         endcase
      default: return 0;
    endcase
  endfunction

  function automatic bit accepts(input int k);
    logic [31:0] w = m_mid[k];
    logic [31:0] msk = m_mask[k];
    bit use_mask = w[30];
    if (!(use_mask && msk[31]) && (w[31] != rx_ext)) return 0;
    if (rx_ext) begin
      for (int b = 0; b < 29; b++)
        if (!(use_mask && msk[b]) && (w[b] != rx_id[b])) return 0;
    end else begin
      for (int b = 0; b < 11; b++)
        if (!(use_mask && msk[b + 18]) && (w[b + 18] != rx_id[b])) return 0;
    end
    return 1;
  endfunction

  task automatic model_update();
    int          dest = -1;
    bit          any = 0;
    logic [31:0] pend_before = m_pend;
    if (rx_valid)
      for (int k = NUM - 1; k >= 0; k--)
        if (m_en[k] && m_dir[k] && accepts(k)) begin
          any = 1;
          if (dest < 0 && !(m_pend[k] && m_prot[k])) dest = k;
        end
    if (wr_en) begin
      int kind = wr_addr[7:5];
      int sub  = wr_addr[4:0];
      if (kind == 0) m_mid[sub] = wr_data;
      if (kind == 5) m_mask[sub] = wr_data;
      if (kind == 6) case (sub)
        0: m_en = wr_data;
        1: m_dir = wr_data;
        2: m_pend = m_pend & ~wr_data;
        3: m_lost = m_lost & ~wr_data;
        4: m_prot = wr_data;
        5: if (wr_data[0]) m_glost = 0;
        default: ;
      endcase
    end
    if (dest >= 0) begin
      logic [31:0] lo = 0, hi = 0;
      for (int b = 0; b < 4; b++) begin
        lo = (lo << 8) | 32'(rx_data[8*b +: 8]);
        hi = (hi << 8) | 32'(rx_data[8*(b+4) +: 8]);
      end
      if (pend_before[dest]) m_lost[dest] = 1'b1;
      m_pend[dest] = 1'b1;
      m_mid[dest][31] = rx_ext;
      m_mid[dest][28:0] = rx_ext ? rx_id : {rx_id[10:0], 18'd0};
      m_ctl[dest] = {27'd0, rx_rtr, rx_dlc};
      m_dlo[dest] = lo;
      m_dhi[dest] = hi;
      m_ts[dest]  = m_time;
    end else if (rx_valid && any) begin
      m_glost = 1;
    end
    m_time = m_time + 1;
  endtask

  // ---------------- check helpers ----------------
  task automatic check(input string t, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s addr=%02h got=%08h exp=%08h", t, rd_addr, got, exp);
    end
  endtask

  task automatic step();
    logic [31:0] exp = model_read(rd_addr);
    model_update();
    @(posedge clk);
    @(negedge clk);
    check(tag, rd_data, exp);
    wr_en = 0;
    rx_valid = 0;
  endtask

  task automatic wreg(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    step();
  endtask

  task automatic rx(input bit ext, input logic [28:0] id, input bit rtr,
                    input logic [3:0] dlc, input logic [63:0] d);
    rx_valid = 1; rx_ext = ext; rx_id = id; rx_rtr = rtr; rx_dlc = dlc; rx_data = d;
    step();
  endtask

  task automatic rdchk(input logic [7:0] a, input logic [31:0] expv);
    rd_addr = a;
    step();
    check({tag, " fixed"}, rd_data, expv);
  endtask

  localparam int GEN = 0, GDIR = 1, GPEND = 2, GLOST = 3, GPROT = 4, GSTAT = 5, GTIME = 6;

  // ---------------- stimulus ----------------
  initial begin
    repeat (3) @(negedge clk);
    check("R1 rd_data in reset", rd_data, 32'd0);
    rst_n = 1;

    tag = "R1";
    rdchk(A(6, GTIME), 32'd0);
    rdchk(A(6, GPEND), 32'd0);
    rdchk(A(6, GSTAT), 32'd0);
    rdchk(A(0, 31), 32'd0);
    rdchk(A(6, GTIME), 32'd4);

    tag = "R12";
    rx(0, 29'h123, 0, 4'd8, 64'h0);
    rdchk(A(6, GPEND), 32'd0);
    rdchk(A(6, GSTAT), 32'd0);

    tag = "R3";
    for (int k = 28; k < 32; k++) begin
      wreg(A(0, k), 32'h4000_0000);
      wreg(A(5, k), 32'hFFFF_FFFF);
    end
    wreg(A(0, 20), 32'h048C_0000);
    wreg(A(0, 10), 32'h4000_0000);
    wreg(A(5, 10), 32'hFFFF_FFFF);
    wreg(A(0, 5), 32'h81AB_CDEF);
    wreg(A(6, GPROT), 32'hE000_0000);
    wreg(A(6, GDIR), 32'hF010_0020);
    tag = "R11";
    rd_addr = A(6, GEN);
    wreg(A(6, GEN), 32'hF010_0420);
    check("R11 old value seen", rd_data, 32'd0);
    rdchk(A(6, GEN), 32'hF010_0420);

    tag = "R4";
    rx(0, 29'h123, 0, 4'd8, 64'h8877_6655_4433_2211);
    rdchk(A(6, GPEND), 32'h8000_0000);
    tag = "R5";
    rdchk(A(0, 31), 32'h448C_0000);
    rdchk(A(1, 31), 32'h0000_0008);
    rdchk(A(2, 31), 32'h1122_3344);
    rdchk(A(3, 31), 32'h5566_7788);
    tag = "R6";
    rd_addr = A(4, 31);
    step();

    tag = "R8";
    rx(1, 29'h00A_BCDE, 1, 4'd2, 64'h0000_0000_0000_BEEF);
    rdchk(A(6, GPEND), 32'hC000_0000);
    rdchk(A(0, 30), 32'hC00A_BCDE);
    rdchk(A(1, 30), 32'h0000_0012);
    tag = "R6";
    rd_addr = A(4, 30);
    step();
    tag = "R8";
    rx(0, 29'h7FF, 0, 4'd1, 64'h5A);
    rx(0, 29'h001, 0, 4'd3, 64'h00C0_FFEE);
    rdchk(A(6, GPEND), 32'hF000_0000);

    tag = "R9";
    rx(0, 29'h555, 0, 4'd4, 64'hDEAD_BEEF);
    rdchk(A(6, GPEND), 32'hF000_0000);
    rdchk(A(6, GLOST), 32'h1000_0000);
    rdchk(A(0, 28), 32'h5554_0000);
    wreg(A(6, GLOST), 32'h1000_0000);
    rdchk(A(6, GLOST), 32'd0);

    tag = "R10";
    wreg(A(6, GEN), 32'hE010_0420);
    rx(0, 29'h124, 0, 4'd0, 64'h0);
    rdchk(A(6, GSTAT), 32'd1);
    rdchk(A(6, GPEND), 32'hF000_0000);

    tag = "R3";
    rx(0, 29'h123, 0, 4'd1, 64'h77);
    rdchk(A(6, GPEND), 32'hF010_0000);
    rx(1, 29'h1AB_CDEF, 0, 4'd8, 64'h0102_0304_0506_0708);
    rdchk(A(6, GPEND), 32'hF010_0020);
    rdchk(A(3, 5), 32'h0403_0201);

    tag = "R2";
    rdchk(A(1, 10), 32'd0);

    tag = "R10";
    rx(1, 29'h000_0777, 0, 4'd0, 64'h0);
    rdchk(A(6, GSTAT), 32'd1);
    wreg(A(6, GSTAT), 32'd0);
    rdchk(A(6, GSTAT), 32'd1);
    wreg(A(6, GSTAT), 32'd1);
    rdchk(A(6, GSTAT), 32'd0);

    tag = "R7";
    wreg(A(6, GPEND), 32'h8000_0000);
    rdchk(A(6, GPEND), 32'h7010_0020);
    rx(0, 29'h3AA, 0, 4'd2, 64'hAB_CD);
    rdchk(A(6, GPEND), 32'hF010_0020);
    wreg(A(6, GEN), 32'hF010_0420);
    wr_en = 1; wr_addr = A(6, GPEND); wr_data = 32'h1000_0000;
    rx(0, 29'h0AA, 0, 4'd1, 64'h99);
    rdchk(A(6, GPEND), 32'hF010_0020);
    rdchk(A(6, GLOST), 32'h1000_0000);

    tag = "R6";
    rdchk(A(6, GTIME), m_time);
    rd_addr = A(4, 28);
    step();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, got=hung exp=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule